// File: doc/BRIEF.md
# Prioritized Interrupt Enable Controller

This block arbitrates 32 level-sensitive interrupt request lines for a processor. Software enables lines through a write-one-to-set register and disables them through a write-one-to-clear register. It assigns each line a 3-bit urgency through eight packed priority registers. Each priority register carries four fields, one per byte lane, and each field sits in the top three bits of its byte. A lower value means more urgent.

Among the lines that are both enabled and high, the controller picks the most urgent one and breaks ties in favour of the lower line number. It presents that line to the processor only when the line is strictly more urgent than the handler now running. When no handler runs, any pending line qualifies. A handler entry handshake saves the running level on a four-entry nesting stack and adopts the new level. A handler exit handshake restores the saved level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all enables and all priority fields are zero, no handler is active, and `irq_valid` stays low even with every request line high.
- R2: A write to word address 0 sets each enable bit whose data bit is 1 and leaves the rest unchanged. Reading address 0 or 1 returns the enable vector.
- R3: A write to word address 1 clears each enable bit whose data bit is 1 and leaves the rest unchanged.
- R4: The priority register at word address 2+n holds line 4n in bits 7:5, line 4n+1 in bits 15:13, line 4n+2 in bits 23:21 and line 4n+3 in bits 31:29. All other bits read as zero and ignore writes.
- R5: A line is pending only while its request input is high and its enable bit is set. A disabled line is never presented.
- R6: The presented line has the lowest priority value among pending lines. Among lines that share that value, the lowest line number wins. `irq_id` and `irq_prio` give its number and value.
- R7: `irq_valid` is high only when the chosen priority is strictly lower in value than the running handler's. An equal or less urgent request waits. With no handler running, any pending line is presented.
- R8: `irq_ack` while `irq_valid` is high saves the running level and makes `irq_prio` the running level. `irq_done` restores the last saved level. `irq_done` with no handler running has no effect.
- R9: At most four handlers nest. With four active, `irq_valid` is low and `irq_ack` is ignored.
- R10: `irq_ack` (with `irq_valid` high) and `irq_done` in the same cycle replace the running level with `irq_prio` and leave the nesting depth unchanged.
- R11: `irq_ack` while `irq_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 32 | Level request per line |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq_valid | output | 1 | Request to the processor |
| irq_id | output | 5 | Number of the presented line |
| irq_prio | output | 3 | Priority value of the presented line |
| irq_ack | input | 1 | Handler entry handshake |
| irq_done | input | 1 | Handler exit handshake |

## Verification
Handler entry and handler exit can land in the same clock edge. A real processor does this when it leaves one handler and at once takes a more urgent one that is waiting. The bench provokes this by pulsing `irq_ack` and `irq_done` together while one handler runs and a more urgent line is presented. It then judges the result only through later arbitration. A line that is less urgent than the new level but more urgent than the old one must stay hidden. After a single exit, the least urgent line must be presented again, which proves the depth did not change.

// File: rtl/irq_ctrl_pkg.sv
// Shared constants and types for the prioritized interrupt controller.
// Assumes byte-wide priority lanes with the value kept in the top bits.
package irq_ctrl_pkg;
    localparam int PRIO_W   = 3;
    localparam int LVL_W    = PRIO_W + 1;          // one extra bit encodes "idle"
    localparam int LANE_W   = 8;
    localparam int LANES    = 4;
    localparam int LANE_LSB = LANE_W - PRIO_W;
    localparam int REG_SET  = 0;
    localparam int REG_CLR  = 1;
    localparam int REG_PRI0 = 2;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    localparam lvl_t LVL_IDLE = lvl_t'(1 << PRIO_W);
endpackage

// File: rtl/irq_cfg_regs.sv
// Enable and priority configuration registers with combinational readback.
// Assumes the bus data width equals the number of request lines.
module irq_cfg_regs
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic [NUM_SRC-1:0] en_q,
    output prio_t              prio_q [NUM_SRC]
);
    function automatic logic [NUM_SRC-1:0] field_mask();
        logic [NUM_SRC-1:0] m = '0;
        for (int k = 0; k < LANES; k++) m[LANE_W*k+LANE_LSB +: PRIO_W] = '1;
        return m;
    endfunction
    localparam logic [NUM_SRC-1:0] FIELD_MASK = field_mask();

    // Register updates: set/clear enables, or load one priority word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(REG_SET))
                en_q <= en_q | bus_wdata;
            else if (bus_addr == ADDR_W'(REG_CLR))
                en_q <= en_q & ~bus_wdata;
            else
                for (int i = 0; i < NUM_SRC; i++)
                    if (bus_addr == ADDR_W'(REG_PRI0 + i / LANES))
                        prio_q[i] <= bus_wdata[LANE_W*(i%LANES)+LANE_LSB +: PRIO_W];
        end
    end

    // Readback mux: enables on both enable addresses, packed fields otherwise.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_SET) || bus_addr == ADDR_W'(REG_CLR))
            bus_rdata = en_q;
        else
            for (int i = 0; i < NUM_SRC; i++)
                if (bus_addr == ADDR_W'(REG_PRI0 + i / LANES))
                    bus_rdata[LANE_W*(i%LANES)+LANE_LSB +: PRIO_W] = prio_q[i];
    end

    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(REG_SET)) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(REG_CLR)) |=> ((en_q & $past(bus_wdata)) == '0));
    a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'(REG_PRI0)) |-> ((bus_rdata & ~FIELD_MASK) == '0));
endmodule

// File: rtl/irq_arbiter.sv
// Picks the most urgent pending line; equal values resolve to the lower index.
// Assumes pending already combines request level and enable.
module irq_arbiter
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    input  prio_t              prio_q [NUM_SRC],
    output logic               found,
    output logic [ID_W-1:0]    sel_id,
    output prio_t              sel_prio
);
    lvl_t best;

    // Linear scan; strict compare keeps the earliest index on ties.
    always_comb begin
        best   = LVL_IDLE;
        sel_id = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && ({1'b0, prio_q[i]} < best)) begin
                best   = {1'b0, prio_q[i]};
                sel_id = ID_W'(i);
            end
        end
        found    = (best != LVL_IDLE);
        sel_prio = best[PRIO_W-1:0];
    end
endmodule

// File: rtl/irq_nest_stack.sv
// Tracks the running handler level and saves preempted levels on a stack.
// Assumes push is only raised when the caller has checked that it may nest.
module irq_nest_stack
    import irq_ctrl_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  logic  pop,
    input  prio_t push_prio,
    output lvl_t  active_lvl,
    output logic  full
);
    logic [CNT_W-1:0] depth;
    lvl_t             stk [DEPTH];
    logic             push_ok, pop_ok;

    assign full    = (depth == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && (depth != '0);

    // Entry/exit bookkeeping; entry plus exit swaps the running level in place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth      <= '0;
            active_lvl <= LVL_IDLE;
            for (int i = 0; i < DEPTH; i++) stk[i] <= LVL_IDLE;
        end else if (push_ok && pop_ok) begin
            active_lvl <= {1'b0, push_prio};
        end else if (push_ok) begin
            stk[depth[PTR_W-1:0]] <= active_lvl;
            active_lvl            <= {1'b0, push_prio};
            depth                 <= depth + 1'b1;
        end else if (pop_ok) begin
            active_lvl <= stk[PTR_W'(depth - 1'b1)];
            depth      <= depth - 1'b1;
        end
    end

    a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(DEPTH));
    a_r8_entry_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (depth == CNT_W'($past(depth) + 1'b1)));
    a_r10_swap_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && pop && depth != '0) |=> $stable(depth));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top: configuration registers, arbiter and nesting stack for 32 level lines.
// Assumes handshakes are single-cycle pulses and requests are synchronous.
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int STACK_DEPTH = 4,
    parameter int ADDR_W      = 4,
    localparam int ID_W       = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               irq_valid,
    output logic [ID_W-1:0]    irq_id,
    output logic [PRIO_W-1:0]  irq_prio,
    input  logic               irq_ack,
    input  logic               irq_done
);
    logic [NUM_SRC-1:0] en_q;
    prio_t              prio_q [NUM_SRC];
    logic               found, full;
    lvl_t               active_lvl;

    irq_cfg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_q(en_q), .prio_q(prio_q)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend(irq_req & en_q), .prio_q(prio_q),
        .found(found), .sel_id(irq_id), .sel_prio(irq_prio)
    );

    irq_nest_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(irq_ack && irq_valid), .pop(irq_done),
        .push_prio(irq_prio), .active_lvl(active_lvl), .full(full)
    );

    // Present only a strictly more urgent request, and only while nesting room remains.
    assign irq_valid = found && ({1'b0, irq_prio} < active_lvl) && !full;

    a_r7_strictly_better: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ({1'b0, irq_prio} < active_lvl));
    a_r5_line_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_req[irq_id] && en_q[irq_id]));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_valid;
    logic [4:0]  irq_id;
    logic [2:0]  irq_prio;
    logic        irq_ack = 1'b0;
    logic        irq_done = 1'b0;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio),
        .irq_ack(irq_ack), .irq_done(irq_done)
    );

    // {request mask, valid, id, prio} with priority of line i = (5i+3) mod 8, idle level
    localparam int VW = 41;
    localparam logic [VW-1:0] VEC [8] = '{
        {32'h0000_0000, 1'b0, 5'd0,  3'd0},
        {32'h0000_0001, 1'b1, 5'd0,  3'd3},
        {32'h0000_0011, 1'b1, 5'd0,  3'd3},
        {32'h0000_0202, 1'b1, 5'd1,  3'd0},
        {32'h8000_0000, 1'b1, 5'd31, 3'd6},
        {32'h0000_4040, 1'b1, 5'd6,  3'd1},
        {32'hF000_0000, 1'b1, 5'd30, 3'd1},
        {32'h0000_0028, 1'b1, 5'd3,  3'd2}
    };

    function automatic logic [31:0] cfg_word(int n);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++) w[8*k+5 +: 3] = 3'(((4*n + k) * 5 + 3) % 8);
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(string tag, logic ev, logic [4:0] eid, logic [2:0] ep);
        if (ev) chk(tag, {23'd0, irq_valid, irq_id, irq_prio}, {23'd0, 1'b1, eid, ep});
        else    chk(tag, {31'd0, irq_valid}, 32'd0);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic set_req(logic [31:0] r);
        @(negedge clk); irq_req = r; #1;
    endtask

    task automatic pulse(logic a, logic d);
        @(negedge clk); irq_ack = a; irq_done = d;
        @(negedge clk); irq_ack = 1'b0; irq_done = 1'b0; #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; irq_req = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup_all();
        for (int n = 0; n < 8; n++) wr(4'(2 + n), cfg_word(n));
        wr(4'd0, 32'hFFFF_FFFF);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        do_reset();
        // R1: reset state
        set_req(32'hFFFF_FFFF);
        chk_irq("R1 no valid after reset", 1'b0, 5'd0, 3'd0);
        rd(4'd0, d); chk("R1 enables zero", d, 32'h0);
        rd(4'd9, d); chk("R1 priority zero", d, 32'h0);
        set_req(32'h0);

        // R4: field placement and unused bits
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, d); chk("R4 unused bits zero", d, 32'hE0E0_E0E0);
        // R2: set register, zeros leave bits alone
        wr(4'd0, 32'h0000_00F0);
        wr(4'd0, 32'h0000_0003);
        rd(4'd0, d); chk("R2 set accumulates", d, 32'h0000_00F3);
        // R3: clear register
        wr(4'd1, 32'h0000_0010);
        rd(4'd1, d); chk("R3 clear one bit", d, 32'h0000_00E3);
        setup_all();
        rd(4'd9, d); chk("R4 layout reg 7", d, cfg_word(7));

        // R6: arbitration table, no handler active
        for (int v = 0; v < 8; v++) begin
            set_req(VEC[v][40:9]);
            chk_irq($sformatf("R6 vector %0d", v), VEC[v][8], VEC[v][7:3], VEC[v][2:0]);
        end

        // R5: disabled line skipped
        wr(4'd1, 32'h0000_0040);
        set_req(32'h0000_0050);
        chk_irq("R5 disabled line skipped", 1'b1, 5'd4, 3'd7);
        set_req(32'h0000_0040);
        chk_irq("R5 only disabled line", 1'b0, 5'd0, 3'd0);
        wr(4'd0, 32'h0000_0040);

        // R9: fill the nesting stack with levels 6,4,2,1
        set_req(32'h8000_0000); pulse(1'b1, 1'b0);
        set_req(32'h0000_0020); pulse(1'b1, 1'b0);
        set_req(32'h0000_0008); pulse(1'b1, 1'b0);
        set_req(32'h0000_0040); pulse(1'b1, 1'b0);
        set_req(32'h0000_0002);
        chk_irq("R9 full stack hides request", 1'b0, 5'd0, 3'd0);
        pulse(1'b1, 1'b0);                 // must be ignored
        pulse(1'b0, 1'b1);                 // back to level 2
        set_req(32'h0000_0040);
        chk_irq("R9 ack at full ignored", 1'b1, 5'd6, 3'd1);
        // R8: unwind to idle
        pulse(1'b0, 1'b1); pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
        set_req(32'h0000_0010);
        chk_irq("R8 exits restore idle", 1'b1, 5'd4, 3'd7);
        pulse(1'b0, 1'b1);                 // exit with nothing active
        set_req(32'h8000_0000); pulse(1'b1, 1'b0);
        set_req(32'h0000_0010);
        chk_irq("R8 entry at level 6 blocks 7", 1'b0, 5'd0, 3'd0);
        pulse(1'b0, 1'b1);
        chk_irq("R8 empty exit ignored", 1'b1, 5'd4, 3'd7);

        // R7 and R10: same-cycle exit and entry
        set_req(32'h0000_0001); pulse(1'b1, 1'b0);
        chk_irq("R7 equal level waits", 1'b0, 5'd0, 3'd0);
        set_req(32'h0000_0040);
        chk_irq("R7 more urgent presented", 1'b1, 5'd6, 3'd1);
        pulse(1'b1, 1'b1);
        set_req(32'h0000_0008);
        chk_irq("R10 level replaced by 1", 1'b0, 5'd0, 3'd0);
        pulse(1'b0, 1'b1);
        set_req(32'h0000_0010);
        chk_irq("R10 depth unchanged", 1'b1, 5'd4, 3'd7);

        // R11: ack without valid
        set_req(32'h0);
        pulse(1'b1, 1'b0);
        set_req(32'h0000_0010);
        chk_irq("R11 stray ack ignored", 1'b1, 5'd4, 3'd7);

        // R1: reset mid-run clears enables and nesting
        set_req(32'h8000_0000); pulse(1'b1, 1'b0);
        do_reset();
        set_req(32'hFFFF_FFFF);
        chk_irq("R1 reset clears enables", 1'b0, 5'd0, 3'd0);
        wr(4'd0, 32'h0000_0010);
        set_req(32'h0000_0010);
        chk_irq("R1 reset clears nesting", 1'b1, 5'd4, 3'd0);

        finish_run();
    end
endmodule